// File: doc/BRIEF.md
# Serial Flash Input Front End with Pause Control

This block sits at the pins of a serial NOR flash model. While the chip select is low, it samples the serial clock and the single input data line and builds bytes most significant bit first. Each completed byte goes to the command decoder with a one-cycle strobe. The serial pins are sampled by the block's own system clock, which must run several times faster than the serial clock. The pins are assumed to be synchronised already.

A low level on the pause pin freezes the transfer without ending it. The bit counter and the partly filled byte keep their values. Serial clock edges and input data are ignored, and the output driver of the second data line is released to high impedance. A pause only starts, and only ends, while the serial clock is low, so no half-sampled bit is ever taken in.

The pause function is switched off in several cases:
- the device runs the four-line protocol;
- the current command uses the pause pin as a fourth data line;
- either of two configuration enable bits is clear;
- the decoder has reported a double-rate command during the current selection.

Releasing the select resets the byte position, the pause state and the double-rate lock.

Top module: `sflash_fe`

## Requirements
- R1: While selected and not paused, each rising edge of `sclk` shifts `dq0_in` into the byte being built, most significant bit first.
- R2: After every eighth accepted bit, `byte_valid` is high for exactly one `clk` cycle with the completed byte on `byte_data`, and the bit position returns to zero.
- R3: While paused, `sclk` edges and `dq0_in` values are ignored, and the bit position and the partial byte keep their values.
- R4: `dq1_oe` is 1 exactly when `sel_n` is 0, `drive_req` is 1 and the block is not paused; it is 0 during a pause.
- R5: A byte whose bits are split by a pause is delivered with the same value as if the pause had not happened.
- R6: A pause starts only when `hold_n` is low while `sclk` is low, and ends only when `hold_n` is high while `sclk` is low. A change of `hold_n` while `sclk` is high has no effect until `sclk` falls.
- R7: With `sel_n` high, no pause is in effect, the bit position is reset, `byte_valid` stays 0 and `dq1_oe` is 0. After reselection, a fresh byte starts at its first bit.
- R8: When `quad_mode` or `quad_xfer` is 1, `hold_n` has no effect: bits keep shifting and `dq1_oe` follows `drive_req`.
- R9: When `cfg_nv_hold_en` or `cfg_ve_hold_en` is 0, `hold_n` has no effect.
- R10: A pulse on `dtr_seen` while selected disables the pause until the next deselection. After a new selection, the pause works again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk | input | 1 | Serial clock, synchronised |
| sel_n | input | 1 | Chip select, active low |
| hold_n | input | 1 | Pause pin, active low |
| dq0_in | input | 1 | Serial input data |
| drive_req | input | 1 | Core wants to drive the second data line |
| quad_mode | input | 1 | Four-line protocol mode active |
| quad_xfer | input | 1 | Current command uses the pause pin as data |
| dtr_seen | input | 1 | Double-rate command recognised (pulse) |
| cfg_nv_hold_en | input | 1 | Persistent config pause enable |
| cfg_ve_hold_en | input | 1 | Volatile config pause enable |
| byte_data | output | 8 | Last completed byte |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |
| dq1_oe | output | 1 | Output enable for the second data line |

## Verification
The hardest case to reach is a pause that starts or ends while the serial clock is high. In that case the pin has changed, but the pause state must not change until the clock falls. The stimulus parks `sclk` high, moves `hold_n`, and confirms that `dq1_oe` stays unchanged until `sclk` is lowered. Random bytes are also interrupted at random bit positions by pauses. During each pause the stimulus toggles the clock with junk data, but only when the pause is enabled. When a disable condition is active, the stimulus holds the pin low and checks that the bits keep flowing.

// File: rtl/sflash_fe_pkg.sv
package sflash_fe_pkg;

    typedef struct packed {
        logic sclk;   // previous sample of the serial clock
        logic hold;   // pause in effect
        logic dtr;    // double-rate lock for this selection
    } fe_ctrl_t;

    function automatic logic pause_permitted(
        input logic quad_mode,
        input logic quad_xfer,
        input logic nv_en,
        input logic ve_en,
        input logic dtr_lock
    );
        return !quad_mode && !quad_xfer && nv_en && ve_en && !dtr_lock;
    endfunction

endpackage

// File: rtl/sflash_fe_hold_gate.sv
module sflash_fe_hold_gate (
    input  logic sel_n,
    input  logic hold_n,
    input  logic sclk,
    input  logic permitted,
    input  logic hold_q,
    output logic hold_d
);
    always_comb begin
        if (sel_n || !permitted) begin
            hold_d = 1'b0;
        end else if (!sclk) begin
            hold_d = !hold_n;
        end else begin
            hold_d = hold_q;
        end
    end
endmodule

// File: rtl/sflash_fe_shift.sv
module sflash_fe_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              din,
    output logic [BYTE_W-1:0] data,
    output logic              valid,
    output logic [$clog2(BYTE_W)-1:0] cnt
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] data;
        logic              valid;
    } shift_t;

    shift_t st_d, st_q;
    logic [BYTE_W-1:0] next_sh;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        next_sh    = {st_q.sh[BYTE_W-2:0], din};
        if (clear) begin
            st_d.sh  = '0;
            st_d.cnt = '0;
        end else if (shift_en) begin
            st_d.sh = next_sh;
            if (st_q.cnt == LAST) begin
                st_d.data  = next_sh;
                st_d.valid = 1'b1;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data  = st_q.data;
    assign valid = st_q.valid;
    assign cnt   = st_q.cnt;
endmodule

// File: rtl/sflash_fe.sv
module sflash_fe
    import sflash_fe_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sel_n,
    input  logic              hold_n,
    input  logic              dq0_in,
    input  logic              drive_req,
    input  logic              quad_mode,
    input  logic              quad_xfer,
    input  logic              dtr_seen,
    input  logic              cfg_nv_hold_en,
    input  logic              cfg_ve_hold_en,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid,
    output logic              dq1_oe
);
    localparam int CNT_W = $clog2(BYTE_W);

    fe_ctrl_t ctrl_d, ctrl_q;
    logic     permitted;
    logic     hold_next;
    logic     sclk_rise;
    logic     shift_en;
    logic [CNT_W-1:0] bit_cnt;

    assign permitted = pause_permitted(quad_mode, quad_xfer, cfg_nv_hold_en,
                                       cfg_ve_hold_en, ctrl_q.dtr | dtr_seen);

    sflash_fe_hold_gate u_gate (
        .sel_n     (sel_n),
        .hold_n    (hold_n),
        .sclk      (sclk),
        .permitted (permitted),
        .hold_q    (ctrl_q.hold),
        .hold_d    (hold_next)
    );

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.sclk = sclk;
        ctrl_d.hold = hold_next;
        ctrl_d.dtr  = sel_n ? 1'b0 : (ctrl_q.dtr | dtr_seen);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign sclk_rise = sclk && !ctrl_q.sclk;
    assign shift_en  = !sel_n && !ctrl_q.hold && sclk_rise;

    sflash_fe_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sel_n),
        .shift_en (shift_en),
        .din      (dq0_in),
        .data     (byte_data),
        .valid    (byte_valid),
        .cnt      (bit_cnt)
    );

    assign dq1_oe = !sel_n && drive_req && !ctrl_q.hold;
endmodule

// File: rtl/sflash_fe_checker.sv
module sflash_fe_checker #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sclk,
    input logic             sel_n,
    input logic             quad_mode,
    input logic             quad_xfer,
    input logic             dtr_seen,
    input logic             cfg_nv_hold_en,
    input logic             cfg_ve_hold_en,
    input logic             byte_valid,
    input logic             dq1_oe,
    input logic             hold_state,
    input logic [CNT_W-1:0] cnt_state
);
    // R3: shift position frozen while paused
    p_freeze_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_state && !sel_n) |=> $stable(cnt_state));

    // R2: a completed byte leaves the position at zero
    p_wrap_on_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> (cnt_state == '0));

    // R4: no drive during a pause
    p_hiz_in_pause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hold_state |-> !dq1_oe);

    // R6: a pause only begins while the serial clock was low
    p_engage_clock_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_state) |-> !$past(sclk));

    // R7: deselection ends any pause and produces no byte
    p_deselect_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> (!hold_state && !byte_valid));

    // R8, R9, R10: disable conditions prevent a pause
    p_disabled_no_pause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (quad_mode || quad_xfer || !cfg_nv_hold_en || !cfg_ve_hold_en || dtr_seen)
        |=> !hold_state);
endmodule

bind sflash_fe sflash_fe_checker #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sclk           (sclk),
    .sel_n          (sel_n),
    .quad_mode      (quad_mode),
    .quad_xfer      (quad_xfer),
    .dtr_seen       (dtr_seen),
    .cfg_nv_hold_en (cfg_nv_hold_en),
    .cfg_ve_hold_en (cfg_ve_hold_en),
    .byte_valid     (byte_valid),
    .dq1_oe         (dq1_oe),
    .hold_state     (ctrl_q.hold),
    .cnt_state      (bit_cnt)
);

// File: tb/sflash_fe_bench.sv
module sflash_fe_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sel_n = 1'b1, hold_n = 1'b1, dq0_in = 1'b0, drive_req = 1'b0;
    logic quad_mode = 1'b0, quad_xfer = 1'b0, dtr_seen = 1'b0;
    logic cfg_nv = 1'b1, cfg_ve = 1'b1;
    logic [7:0] byte_data;
    logic byte_valid, dq1_oe;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;
    bit done = 1'b0;
    logic [7:0] cap_q[$];

    always #10 clk = ~clk;

    sflash_fe u_sflash_fe (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sel_n(sel_n), .hold_n(hold_n),
        .dq0_in(dq0_in), .drive_req(drive_req), .quad_mode(quad_mode),
        .quad_xfer(quad_xfer), .dtr_seen(dtr_seen), .cfg_nv_hold_en(cfg_nv),
        .cfg_ve_hold_en(cfg_ve), .byte_data(byte_data), .byte_valid(byte_valid),
        .dq1_oe(dq1_oe)
    );

    always @(negedge clk) if (byte_valid) cap_q.push_back(byte_data);

    function automatic logic pause_on(input logic qm, qx, nv, ve, dtr);
        return !qm && !qx && nv && ve && !dtr;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sclk = 1'b0; dq0_in = b; wait_clk(2);
        sclk = 1'b1; wait_clk(2);
    endtask

    task automatic send_bits(input logic [7:0] v, input int from, input int upto);
        for (int i = from; i < upto; i++) bit_out(v[7-i]);
    endtask

    task automatic expect_byte(input string req, input logic [7:0] exp);
        wait_clk(1);
        check(req, cap_q.size(), 1);
        if (cap_q.size() == 1) check(req, cap_q[0], exp);
        cap_q.delete();
    endtask

    task automatic select();
        sclk = 1'b0; wait_clk(1); sel_n = 1'b0; wait_clk(2);
    endtask

    task automatic deselect();
        sclk = 1'b0; wait_clk(1); sel_n = 1'b1; wait_clk(2);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                done = 1'b1;
                n_chk++; n_err++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h5F1A_2C07));
        wait_clk(3);
        check("R7 reset valid", byte_valid, 0);
        check("R7 reset oe", dq1_oe, 0);
        check("R2 reset data", byte_data, 8'h00);
        rst_n = 1'b1;
        wait_clk(2);

        // R1/R2 directed bytes
        select();
        drive_req = 1'b1; wait_clk(1);
        check("R4 oe selected", dq1_oe, 1);
        send_bits(8'hA5, 0, 8); expect_byte("R1 byte A5", 8'hA5);
        send_bits(8'h3C, 0, 8); expect_byte("R2 second byte", 8'h3C);

        // R3/R5 byte split by pause with junk clocks
        send_bits(8'hC9, 0, 3);
        sclk = 1'b0; wait_clk(1); hold_n = 1'b0; wait_clk(2);
        check("R4 oe during pause", dq1_oe, 0);
        for (int k = 0; k < 6; k++) bit_out(k[0]);
        sclk = 1'b0; wait_clk(1);
        check("R3 no byte in pause", cap_q.size(), 0);
        hold_n = 1'b1; wait_clk(2);
        check("R4 oe after release", dq1_oe, 1);
        send_bits(8'hC9, 3, 8); expect_byte("R5 split byte", 8'hC9);

        // R6 pin change with clock high waits for clock low
        sclk = 1'b1; wait_clk(1); hold_n = 1'b0; wait_clk(3);
        check("R6 no engage while sclk high", dq1_oe, 1);
        sclk = 1'b0; wait_clk(2);
        check("R6 engage at sclk low", dq1_oe, 0);
        sclk = 1'b1; wait_clk(1); hold_n = 1'b1; wait_clk(3);
        check("R6 no release while sclk high", dq1_oe, 0);
        sclk = 1'b0; wait_clk(2);
        check("R6 release at sclk low", dq1_oe, 1);

        // R7 deselect mid-byte then fresh byte
        send_bits(8'hFF, 0, 4);
        deselect();
        check("R7 oe deselected", dq1_oe, 0);
        select();
        send_bits(8'h1E, 0, 8); expect_byte("R7 fresh byte", 8'h1E);
        deselect(); hold_n = 1'b0; wait_clk(2); select();
        check("R7 pin low while deselected earlier", dq1_oe, 0);
        hold_n = 1'b1; wait_clk(2);

        // R8 / R9 disable conditions
        for (int m = 0; m < 4; m++) begin
            quad_mode = (m == 0); quad_xfer = (m == 1);
            cfg_nv = (m != 2); cfg_ve = (m != 3);
            wait_clk(1); hold_n = 1'b0; wait_clk(2);
            check(m < 2 ? "R8 oe kept" : "R9 oe kept", dq1_oe, 1);
            v = 8'(m * 37 + 11);
            send_bits(v, 0, 8);
            expect_byte(m < 2 ? "R8 byte flows" : "R9 byte flows", v);
            sclk = 1'b0; hold_n = 1'b1; wait_clk(2);
        end
        quad_mode = 1'b0; quad_xfer = 1'b0; cfg_nv = 1'b1; cfg_ve = 1'b1;

        // R10 double-rate lock until deselect
        dtr_seen = 1'b1; wait_clk(1); dtr_seen = 1'b0;
        hold_n = 1'b0; wait_clk(2);
        check("R10 oe kept after dtr", dq1_oe, 1);
        send_bits(8'h96, 0, 8); expect_byte("R10 byte flows", 8'h96);
        sclk = 1'b0; hold_n = 1'b1;
        deselect(); select();
        hold_n = 1'b0; wait_clk(2);
        check("R10 pause restored", dq1_oe, 0);
        hold_n = 1'b1; wait_clk(2);

        // random bytes with pauses at random positions and random disables
        for (int t = 0; t < 60; t++) begin
            int pos;
            logic en;
            v = 8'($urandom);
            pos = int'($urandom_range(0, 7));
            quad_mode = ($urandom_range(0, 5) == 0);
            quad_xfer = ($urandom_range(0, 5) == 0);
            cfg_nv = ($urandom_range(0, 5) != 0);
            cfg_ve = ($urandom_range(0, 5) != 0);
            en = pause_on(quad_mode, quad_xfer, cfg_nv, cfg_ve, 1'b0);
            send_bits(v, 0, pos);
            sclk = 1'b0; wait_clk(1); hold_n = 1'b0; wait_clk(2);
            check(en ? "R4 random pause oe" : "R9 random disabled oe", dq1_oe, en ? 0 : 1);
            if (en) for (int k = 0; k < 3; k++) bit_out(1'($urandom));
            sclk = 1'b0; hold_n = 1'b1; wait_clk(2);
            send_bits(v, pos, 8);
            expect_byte("R5 random byte", v);
        end

        deselect();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end
endmodule